// File: doc/BRIEF.md
# Processor status trace output port

This block sits between a processor core and an external debugger. It drives eight trace bits and a half-rate companion clock. Each trace window is two core cycles long. At the start of a window the block captures a 4-bit status code and a 4-bit captured-value nibble from the core. It holds them on the trace bits for both cycles of the window. The companion clock is low in the first cycle and high in the second, so its rising edge falls in the middle of the valid data. The debugger samples the trace bits on that rising edge.

The trace clock stays idle until the core reports its first non-zero status after reset. A quiet-mode input freezes the trace outputs without touching the request logic. When quiet mode ends, output resumes on a fresh window boundary and the debugger must resynchronize. A manual breakpoint input is synchronized and edge-detected. It is then held as a request until the core acknowledges it. A per-request disable input chooses the kind of request: a halt request, or a debug interrupt request. Once a halt is acknowledged, every later window shows the halt code 0xF on both nibbles until the core signals resume.

Top module: `trace_port`

## Requirements
- R1: Every window is two core cycles long. In the first cycle of a window the trace bits load {data nibble in bits 7:4, status nibble in bits 3:0}. The trace bits never change at any other time.
- R2: The trace clock is driven low in the first cycle of each window and high in the second, so its rising edge is one cycle after the data change.
- R3: After reset, the trace clock and trace bits stay 0 while the status input is 0. In the first cycle in which the status input is non-zero, a window starts and loads the inputs of that cycle.
- R4: While quiet is high, the trace clock and trace bits hold their values. In the first clock edge after quiet drops, a new window loads the live inputs with the trace clock low.
- R5: After a halt request is acknowledged, each window loads 0xFF instead of the inputs.
- R6: A breakpoint taken while the disable input is 0 raises the halt request. A breakpoint taken while the disable input is 1 raises the interrupt request. Only one request is high at a time, and it stays high until the acknowledge input is high for a cycle.
- R7: A rising edge on the breakpoint input, set up before clock edge k, makes the request output high after edge k+2. A breakpoint input that stays high does not raise a second request after the acknowledge.
- R8: Reset is synchronous and active high. It clears the trace bits, the trace clock, both requests and the halted state.
- R9: Resume clears the halted state, and later windows carry the live inputs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_i | input | 4 | Processor status code for the current slot |
| capt_i | input | 4 | Captured address or data nibble |
| quiet_i | input | 1 | Freeze trace outputs |
| brk_i | input | 1 | Manual breakpoint, asynchronous, active high |
| brk_dis_i | input | 1 | 1: breakpoint raises an interrupt request instead of a halt |
| ack_i | input | 1 | Core acknowledges the pending request |
| resume_i | input | 1 | Core leaves the halted state |
| trc_data_o | output | 8 | Trace bits {captured nibble, status nibble} |
| trc_clk_o | output | 1 | Half-rate trace clock |
| halt_req_o | output | 1 | Halt request to the core |
| irq_req_o | output | 1 | Debug interrupt request to the core |

## Verification
The hardest situation to reach is quiet mode starting part-way through a window while a breakpoint request is in flight. This brings together the hold, the window restart and the halted substitution. Random stimulus makes quiet, breakpoint, acknowledge and resume events frequent and lets them overlap. A cycle model in the bench tracks the expected value of every output. Directed sequences also cover the startup gate, a quiet stretch, and a breakpoint held high past its acknowledge.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic {
    BRK_HALT = 1'b0,
    BRK_IRQ  = 1'b1
  } brk_kind_e;
endpackage

// File: rtl/brk_ctl.sv
module brk_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic brk_i,
  input  logic dis_i,
  input  logic ack_i,
  input  logic resume_i,
  output logic halt_req_o,
  output logic irq_req_o,
  output logic halted_o
);
  import trace_pkg::*;

  logic [SYNC_STAGES:0] sh_q;
  logic                 pend_q;
  brk_kind_e            kind_q;
  logic                 halted_q;
  logic                 rise;
  logic                 take_ack;

  assign rise     = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign take_ack = pend_q & ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      pend_q   <= 1'b0;
      kind_q   <= BRK_HALT;
      halted_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[SYNC_STAGES-1:0], brk_i};
      if (resume_i) halted_q <= 1'b0;
      if (take_ack) begin
        pend_q <= 1'b0;
        if (kind_q == BRK_HALT) halted_q <= 1'b1;
      end else if (rise && !pend_q) begin
        pend_q <= 1'b1;
        kind_q <= dis_i ? BRK_IRQ : BRK_HALT;
      end
    end
  end

  assign halt_req_o = pend_q && (kind_q == BRK_HALT);
  assign irq_req_o  = pend_q && (kind_q == BRK_IRQ);
  assign halted_o   = halted_q;

  // R6: requests are exclusive
  p_req_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halt_req_o, irq_req_o}));
  // R6: request held until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((halt_req_o || irq_req_o) && !ack_i) |=> (halt_req_o || irq_req_o));
  // R6: acknowledge drops the request
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
    ((halt_req_o || irq_req_o) && ack_i) |=> !(halt_req_o || irq_req_o));
  // R5: acknowledged halt enters halted state
  p_halt_enter_r5: assert property (@(posedge clk) disable iff (rst)
    (halt_req_o && ack_i) |=> halted_o);
endmodule

// File: rtl/trace_seq.sv
module trace_seq #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               quiet_i,
  input  logic [NIB_W-1:0]   stat_i,
  input  logic [NIB_W-1:0]   capt_i,
  input  logic               halted_i,
  output logic [2*NIB_W-1:0] trc_data_o,
  output logic               trc_clk_o
);
  localparam int OUT_W = 2 * NIB_W;

  logic             started_q;
  logic             slot_q;
  logic             clk_q;
  logic [OUT_W-1:0] data_q;
  logic             start_now;

  assign start_now = started_q | (stat_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      slot_q    <= 1'b0;
      clk_q     <= 1'b0;
      data_q    <= '0;
    end else begin
      started_q <= start_now;
      if (quiet_i) begin
        slot_q <= 1'b0;
      end else if (!slot_q && start_now) begin
        data_q <= halted_i ? {OUT_W{1'b1}} : {capt_i, stat_i};
        clk_q  <= 1'b0;
        slot_q <= 1'b1;
      end else if (slot_q) begin
        clk_q  <= 1'b1;
        slot_q <= 1'b0;
      end
    end
  end

  assign trc_data_o = data_q;
  assign trc_clk_o  = clk_q;

  // R3: clock idle before start
  p_idle_before_start_r3: assert property (@(posedge clk) disable iff (rst)
    !started_q |-> !clk_q);
  // R4: quiet freezes outputs
  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (rst)
    quiet_i |=> ($stable(data_q) && $stable(clk_q)));
  // R1: data only changes with clock low
  p_data_on_low_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_q) |-> !clk_q);
  // R2: clock rises in mid-window, data steady
  p_rise_mid_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_q) |-> $stable(data_q));
  // R5: halted loads all ones
  p_halt_code_r5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(data_q) && $past(halted_i)) |-> (data_q == {OUT_W{1'b1}}));
endmodule

// File: rtl/trace_port.sv
module trace_port #(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NIB_W-1:0]   stat_i,
  input  logic [NIB_W-1:0]   capt_i,
  input  logic               quiet_i,
  input  logic               brk_i,
  input  logic               brk_dis_i,
  input  logic               ack_i,
  input  logic               resume_i,
  output logic [2*NIB_W-1:0] trc_data_o,
  output logic               trc_clk_o,
  output logic               halt_req_o,
  output logic               irq_req_o
);
  logic halted;

  brk_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_brk (
    .clk        (clk),
    .rst        (rst),
    .brk_i      (brk_i),
    .dis_i      (brk_dis_i),
    .ack_i      (ack_i),
    .resume_i   (resume_i),
    .halt_req_o (halt_req_o),
    .irq_req_o  (irq_req_o),
    .halted_o   (halted)
  );

  trace_seq #(.NIB_W(NIB_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .quiet_i    (quiet_i),
    .stat_i     (stat_i),
    .capt_i     (capt_i),
    .halted_i   (halted),
    .trc_data_o (trc_data_o),
    .trc_clk_o  (trc_clk_o)
  );

  // R8: outputs cleared by reset
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (trc_data_o == '0 && !trc_clk_o && !halt_req_o && !irq_req_o));
endmodule

// File: tb/test_trace_port.sv
module test_trace_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] stat_i = '0, capt_i = '0;
  logic       quiet_i = 1'b0, brk_i = 1'b0, brk_dis_i = 1'b0;
  logic       ack_i = 1'b0, resume_i = 1'b0;
  logic [7:0] trc_data_o;
  logic       trc_clk_o, halt_req_o, irq_req_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  trace_port i_trace_port (
    .clk(clk), .rst(rst), .stat_i(stat_i), .capt_i(capt_i),
    .quiet_i(quiet_i), .brk_i(brk_i), .brk_dis_i(brk_dis_i),
    .ack_i(ack_i), .resume_i(resume_i), .trc_data_o(trc_data_o),
    .trc_clk_o(trc_clk_o), .halt_req_o(halt_req_o), .irq_req_o(irq_req_o)
  );

  // reference model built from the requirements
  logic [2:0] m_sh;
  logic       m_pend, m_kind, m_halted, m_started, m_slot, m_clk;
  logic [7:0] m_data;

  function automatic logic [7:0] load_val(input logic h, input logic [3:0] c, input logic [3:0] s);
    return h ? 8'hFF : {c, s};
  endfunction

  always @(posedge clk) begin
    logic rise, go;
    if (rst) begin
      m_sh = '0; m_pend = 0; m_kind = 0; m_halted = 0;
      m_started = 0; m_slot = 0; m_clk = 0; m_data = '0;
    end else begin
      go = m_started | (stat_i != 0);
      if (quiet_i) m_slot = 0;
      else if (!m_slot && go) begin
        m_data = load_val(m_halted, capt_i, stat_i); m_clk = 0; m_slot = 1;
      end else if (m_slot) begin
        m_clk = 1; m_slot = 0;
      end
      m_started = go;
      rise = m_sh[1] & ~m_sh[2];
      if (resume_i) m_halted = 0;
      if (m_pend && ack_i) begin
        m_pend = 0;
        if (!m_kind) m_halted = 1;
      end else if (rise && !m_pend) begin
        m_pend = 1; m_kind = brk_dis_i;
      end
      m_sh = {m_sh[1:0], brk_i};
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check("R1 trace data", trc_data_o, m_data);
      check("R2 trace clock", trc_clk_o, m_clk);
      check("R6 halt request", halt_req_o, m_pend & ~m_kind);
      check("R6 irq request", irq_req_o, m_pend & m_kind);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] hd; logic hc;
    void'($urandom(32'd1234));
    cyc(3);
    check("R8 reset data", trc_data_o, 8'h00);
    check("R8 reset clock", trc_clk_o, 1'b0);
    check("R8 reset requests", {halt_req_o, irq_req_o}, 2'b00);
    rst = 1'b0; cmp_en = 1'b1;
    capt_i = 4'h7;
    cyc(5);
    check("R3 idle clock", trc_clk_o, 1'b0);
    check("R3 idle data", trc_data_o, 8'h00);
    stat_i = 4'hC; capt_i = 4'h5;
    cyc(1);
    check("R3 first window data", trc_data_o, 8'h5C);
    check("R3 first window clock", trc_clk_o, 1'b0);
    stat_i = 4'h0; capt_i = 4'h0;
    cyc(1);
    check("R2 clock high mid window", trc_clk_o, 1'b1);
    check("R1 data held", trc_data_o, 8'h5C);
    stat_i = 4'h3; capt_i = 4'hA;
    cyc(1);
    check("R1 next load", trc_data_o, 8'hA3);
    // quiet stretch
    quiet_i = 1'b1;
    cyc(1); hd = trc_data_o; hc = trc_clk_o;
    stat_i = 4'h9; capt_i = 4'h6;
    cyc(5);
    check("R4 quiet data hold", trc_data_o, hd);
    check("R4 quiet clock hold", trc_clk_o, hc);
    quiet_i = 1'b0;
    cyc(1);
    check("R4 resume load", trc_data_o, 8'h69);
    check("R4 resume clock low", trc_clk_o, 1'b0);
    // halt breakpoint
    brk_dis_i = 1'b0; brk_i = 1'b1;
    cyc(2);
    check("R7 not yet requested", halt_req_o, 1'b0);
    cyc(1);
    check("R7 request after sync", halt_req_o, 1'b1);
    check("R6 halt kind only", irq_req_o, 1'b0);
    cyc(3);
    check("R6 held without ack", halt_req_o, 1'b1);
    ack_i = 1'b1; cyc(1); ack_i = 1'b0;
    cyc(4);
    check("R5 halt code", trc_data_o, 8'hFF);
    check("R7 no repeat while held", halt_req_o, 1'b0);
    brk_i = 1'b0;
    resume_i = 1'b1; cyc(1); resume_i = 1'b0;
    stat_i = 4'h2; capt_i = 4'h4;
    cyc(4);
    check("R9 live data after resume", trc_data_o, 8'h42);
    // interrupt breakpoint
    brk_dis_i = 1'b1; brk_i = 1'b1;
    cyc(3);
    check("R6 irq request", irq_req_o, 1'b1);
    check("R6 no halt request", halt_req_o, 1'b0);
    brk_dis_i = 1'b0;
    cyc(2);
    check("R6 kind latched", irq_req_o, 1'b1);
    ack_i = 1'b1; cyc(1); ack_i = 1'b0; brk_i = 1'b0;
    check("R6 irq cleared", irq_req_o, 1'b0);
    cyc(4);
    check("R5 no halt after irq", trc_data_o, 8'h42);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      stat_i    = 4'($urandom);
      capt_i    = 4'($urandom);
      quiet_i   = ($urandom % 8) == 0;
      if (($urandom % 6) == 0) brk_i = ~brk_i;
      brk_dis_i = 1'($urandom);
      ack_i     = ($urandom % 5) == 0;
      resume_i  = ($urandom % 20) == 0;
      cyc(1);
    end
    // reset mid-run
    rst = 1'b1; cyc(2);
    check("R8 reset mid run data", trc_data_o, 8'h00);
    check("R8 reset mid run requests", {halt_req_o, irq_req_o}, 2'b00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule